// File: doc/BRIEF.md
# Multi-Bus Hotplug Status Register Bank

This block keeps, for each of several downstream buses, three 32-bit slot masks: slots with a newly inserted device, slots with a pending removal request, and slots that firmware may remove. Platform logic reports insertions and removal requests as one-cycle events tagged with a bus index and a slot number. Each event sets the matching bit and produces a one-cycle notification pulse.

Firmware works through a small word-wide register window. It first picks a bus through a select register, then reads that bus's masks. Reading the insertion mask also empties it, so the next read shows only new arrivals. Firmware asks for removal by writing a slot mask to the eject register. Only the lowest set bit of the written value counts. The eject clears that slot in both pending masks and emits an eject-done strobe that names the bus and the slot.

A legacy mode keeps the insertion mask after a read and pins the bus select to bus 0. A sweep request runs through every bus, ejects each pending removal, and then reloads each bus's removable mask from a per-bus non-hotpluggable flag input.

Top module: `hp_status_bank`

## Requirements
- R1: After asynchronous reset, every insertion and removal mask is zero, every removable mask is all ones, bus select is 0, and `event_pulse`, `eject_valid` and `sweep_busy` are low.
- R2: A plug event sets bit `slot` of the insertion mask of bus `plug_bus`, and an unplug event sets bit `slot` of the removal mask of bus `unplug_bus`. Either event drives `event_pulse` high for exactly the cycle after the event.
- R3: Outside legacy mode, a read at byte offset 0x00 returns the selected bus's insertion mask and clears it to zero. If a plug event for the same bus arrives in the same cycle as that read, the event's bit is kept.
- R4: In legacy mode (`legacy_mode`=1), a read at offset 0x00 leaves the insertion mask unchanged, and any write to offset 0x10 stores 0 in bus select.
- R5: Reads have no side effects at these offsets: 0x04 returns the removal mask, 0x0C returns the removable mask, and 0x10 returns the stored bus select.
- R6: A read at offset 0x08 returns zero. A read at an offset that is not a multiple of 4, or that is 0x14 or above, returns zero, and a write there has no effect. `reg_rdata` is zero whenever `reg_rd` is low.
- R7: While bus select holds a value of `NUM_BUS` or greater, every read returns zero, including a read of the select register, and eject writes are ignored.
- R8: A write at offset 0x08 with nonzero data uses the lowest set bit of the data as the slot. It clears that slot in the selected bus's insertion and removal masks, and one cycle later `eject_valid` pulses with `eject_bus` and `eject_slot`. A write of zero data does nothing.
- R9: A `sweep_req` pulse raises `sweep_busy` in the next cycle. The sweep then ejects every pending removal one per cycle, in ascending order of bus and then slot, and signals each eject through the eject strobe. When it finishes, every removal mask is zero and each removable mask equals the bitwise inverse of that bus's 32-bit field in `nohp_mask` (bus b at bits 32b+31..32b).
- R10: While `sweep_busy` is high, eject writes from the register port are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Keep insertion mask on read, pin bus select to 0 |
| nohp_mask | input | NUM_BUS*32 | Per-bus flags for slots that cannot be hot-removed |
| reg_addr | input | 5 | Register byte offset |
| reg_rd | input | 1 | Read strobe, data returned in the same cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| plug_valid | input | 1 | Device inserted event |
| plug_bus | input | BUS_W | Bus index of the insertion |
| plug_slot | input | 5 | Slot of the insertion |
| unplug_valid | input | 1 | Removal request event |
| unplug_bus | input | BUS_W | Bus index of the removal request |
| unplug_slot | input | 5 | Slot of the removal request |
| sweep_req | input | 1 | Start the pending-removal sweep |
| sweep_busy | output | 1 | Sweep in progress |
| event_pulse | output | 1 | One-cycle notification after any event |
| eject_valid | output | 1 | Eject-done strobe |
| eject_bus | output | BUS_W | Bus of the completed eject |
| eject_slot | output | 5 | Slot of the completed eject |

## Verification
The hardest case to reach is a plug event and a clearing read of the same bus's insertion mask in the same cycle. A directed step drives both together and then reads the mask again to confirm the new bit survived. Another hard case is an eject write that arrives during a sweep. The bench starts a sweep with removals pending on several buses, injects an eject write in the middle of it, and compares the exact sequence of eject strobes against an order computed from its model. Random plug, unplug, select, read and eject traffic, with select values both inside and outside the bus range, covers the rest of the mask behaviour.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam int MASK_W = 32;
  localparam int SLOT_W = 5;

  typedef enum logic [2:0] {
    RG_INS  = 3'd0,
    RG_REM  = 3'd1,
    RG_EJ   = 3'd2,
    RG_RMV  = 3'd3,
    RG_SEL  = 3'd4,
    RG_NONE = 3'd5
  } reg_sel_e;

  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_SCAN = 1'b1
  } sw_state_e;

  // Index of the lowest set bit; MASK_W when no bit is set.
  function automatic logic [SLOT_W:0] lowest_set(input logic [MASK_W-1:0] v);
    logic [SLOT_W:0] r;
    r = (SLOT_W+1)'(MASK_W);
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (v[i]) r = (SLOT_W+1)'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
  import hp_pkg::*;
(
  input  logic [4:0] addr,
  output reg_sel_e   sel
);

  always_comb begin
    sel = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      unique case (addr[4:2])
        3'd0:    sel = RG_INS;
        3'd1:    sel = RG_REM;
        3'd2:    sel = RG_EJ;
        3'd3:    sel = RG_RMV;
        3'd4:    sel = RG_SEL;
        default: sel = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/hp_mask_bank.sv
module hp_mask_bank
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int BUS_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            plug_en,
  input  logic [BUS_W-1:0]                plug_bus,
  input  logic [SLOT_W-1:0]               plug_slot,
  input  logic                            unp_en,
  input  logic [BUS_W-1:0]                unp_bus,
  input  logic [SLOT_W-1:0]               unp_slot,
  input  logic                            rdclr_en,
  input  logic [BUS_W-1:0]                rdclr_bus,
  input  logic                            ej_en,
  input  logic [BUS_W-1:0]                ej_bus,
  input  logic [SLOT_W-1:0]               ej_slot,
  input  logic                            rmv_ld_en,
  input  logic [BUS_W-1:0]                rmv_ld_bus,
  input  logic [MASK_W-1:0]               rmv_ld_val,
  output logic [NUM_BUS-1:0][MASK_W-1:0]  ins_q,
  output logic [NUM_BUS-1:0][MASK_W-1:0]  rem_q,
  output logic [NUM_BUS-1:0][MASK_W-1:0]  rmv_q
);

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    localparam logic [BUS_W-1:0] BIDX = BUS_W'(b);

    logic [MASK_W-1:0] ins_r, rem_r, rmv_r;
    logic [MASK_W-1:0] ins_d, rem_d, rmv_d;
    logic              hit_plug, hit_unp, hit_clr, hit_ej, hit_ld, upd;

    assign hit_plug = plug_en   && (plug_bus   == BIDX);
    assign hit_unp  = unp_en    && (unp_bus    == BIDX);
    assign hit_clr  = rdclr_en  && (rdclr_bus  == BIDX);
    assign hit_ej   = ej_en     && (ej_bus     == BIDX);
    assign hit_ld   = rmv_ld_en && (rmv_ld_bus == BIDX);
    assign upd      = hit_plug | hit_unp | hit_clr | hit_ej | hit_ld;

    // Order matters: clears first, then new events so none is lost.
    always_comb begin
      ins_d = ins_r;
      rem_d = rem_r;
      rmv_d = rmv_r;
      if (hit_clr) ins_d = '0;
      if (hit_ej) begin
        ins_d[ej_slot] = 1'b0;
        rem_d[ej_slot] = 1'b0;
      end
      if (hit_plug) ins_d[plug_slot] = 1'b1;
      if (hit_unp)  rem_d[unp_slot]  = 1'b1;
      if (hit_ld)   rmv_d = rmv_ld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ins_r <= '0;
        rem_r <= '0;
        rmv_r <= '1;
      end else if (upd) begin
        ins_r <= ins_d;
        rem_r <= rem_d;
        rmv_r <= rmv_d;
      end
    end

    assign ins_q[b] = ins_r;
    assign rem_q[b] = rem_r;
    assign rmv_q[b] = rmv_r;
  end

endmodule

// File: rtl/hp_sweep_fsm.sv
module hp_sweep_fsm
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int BUS_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [NUM_BUS-1:0][MASK_W-1:0]  rem_q,
  output logic                            busy,
  output logic                            ej_en,
  output logic [BUS_W-1:0]                ej_bus,
  output logic [SLOT_W-1:0]               ej_slot,
  output logic                            rmv_ld_en,
  output logic [BUS_W-1:0]                rmv_ld_bus
);

  localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

  sw_state_e        state_q, state_d;
  logic [BUS_W-1:0] bus_q, bus_d;
  logic [SLOT_W:0]  low;
  logic             pending;

  assign pending = |rem_q[bus_q];
  assign low     = lowest_set(rem_q[bus_q]);

  always_comb begin
    state_d   = state_q;
    bus_d     = bus_q;
    ej_en     = 1'b0;
    rmv_ld_en = 1'b0;
    unique case (state_q)
      SW_IDLE: begin
        if (start) begin
          state_d = SW_SCAN;
          bus_d   = '0;
        end
      end
      SW_SCAN: begin
        if (pending) begin
          ej_en = 1'b1;
        end else begin
          rmv_ld_en = 1'b1;
          if (bus_q == LAST_BUS) state_d = SW_IDLE;
          else                   bus_d   = bus_q + 1'b1;
        end
      end
      default: state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      bus_q   <= '0;
    end else begin
      state_q <= state_d;
      bus_q   <= bus_d;
    end
  end

  assign busy       = (state_q == SW_SCAN);
  assign ej_bus     = bus_q;
  assign ej_slot    = low[SLOT_W-1:0];
  assign rmv_ld_bus = bus_q;

endmodule

// File: rtl/hp_status_bank.sv
module hp_status_bank
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       legacy_mode,
  input  logic [NUM_BUS*MASK_W-1:0]  nohp_mask,
  input  logic [4:0]                 reg_addr,
  input  logic                       reg_rd,
  input  logic                       reg_wr,
  input  logic [MASK_W-1:0]          reg_wdata,
  output logic [MASK_W-1:0]          reg_rdata,
  input  logic                       plug_valid,
  input  logic [BUS_W-1:0]           plug_bus,
  input  logic [SLOT_W-1:0]          plug_slot,
  input  logic                       unplug_valid,
  input  logic [BUS_W-1:0]           unplug_bus,
  input  logic [SLOT_W-1:0]          unplug_slot,
  input  logic                       sweep_req,
  output logic                       sweep_busy,
  output logic                       event_pulse,
  output logic                       eject_valid,
  output logic [BUS_W-1:0]           eject_bus,
  output logic [SLOT_W-1:0]          eject_slot
);

  reg_sel_e                        rsel;
  logic [MASK_W-1:0]               sel_q, sel_d;
  logic                            sel_ok, sel_we;
  logic [BUS_W-1:0]                sel_idx;
  logic                            plug_ok, unp_ok;
  logic [NUM_BUS-1:0][MASK_W-1:0]  ins_q, rem_q, rmv_q;
  logic [MASK_W-1:0]               nohp_arr [NUM_BUS];

  logic                            sw_ej_en, sw_ld_en;
  logic [BUS_W-1:0]                sw_ej_bus, sw_ld_bus;
  logic [SLOT_W-1:0]               sw_ej_slot;

  logic                            wr_ej;
  logic [SLOT_W:0]                 wr_low;
  logic                            rdclr_en;
  logic                            ej_en;
  logic [BUS_W-1:0]                ej_bus;
  logic [SLOT_W-1:0]               ej_slot;

  logic                            ev_q;
  logic                            ejv_q;
  logic [BUS_W-1:0]                ejb_q;
  logic [SLOT_W-1:0]               ejs_q;

  hp_reg_decode u_dec (
    .addr (reg_addr),
    .sel  (rsel)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_nohp
    assign nohp_arr[b] = nohp_mask[b*MASK_W +: MASK_W];
  end

  // Event bus range check only exists when the index can exceed the count.
  if (NUM_BUS == (1 << BUS_W)) begin : g_full_range
    assign plug_ok = plug_valid;
    assign unp_ok  = unplug_valid;
  end else begin : g_part_range
    assign plug_ok = plug_valid   && (32'(plug_bus)   < NUM_BUS);
    assign unp_ok  = unplug_valid && (32'(unplug_bus) < NUM_BUS);
  end

  assign sel_ok  = (sel_q < NUM_BUS);
  assign sel_idx = sel_q[BUS_W-1:0];

  // Bus select register
  assign sel_we = reg_wr && (rsel == RG_SEL);
  assign sel_d  = legacy_mode ? '0 : reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_d;
  end

  // Read path
  always_comb begin
    reg_rdata = '0;
    if (reg_rd && sel_ok) begin
      unique case (rsel)
        RG_INS:  reg_rdata = ins_q[sel_idx];
        RG_REM:  reg_rdata = rem_q[sel_idx];
        RG_RMV:  reg_rdata = rmv_q[sel_idx];
        RG_SEL:  reg_rdata = sel_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign rdclr_en = reg_rd && (rsel == RG_INS) && sel_ok && !legacy_mode;

  // Eject: register writes only when no sweep owns the eject path
  assign wr_low = lowest_set(reg_wdata);
  assign wr_ej  = reg_wr && (rsel == RG_EJ) && sel_ok && !sweep_busy &&
                  !wr_low[SLOT_W];

  assign ej_en   = sw_ej_en | wr_ej;
  assign ej_bus  = sw_ej_en ? sw_ej_bus  : sel_idx;
  assign ej_slot = sw_ej_en ? sw_ej_slot : wr_low[SLOT_W-1:0];

  hp_sweep_fsm #(
    .NUM_BUS (NUM_BUS),
    .BUS_W   (BUS_W)
  ) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sweep_req),
    .rem_q      (rem_q),
    .busy       (sweep_busy),
    .ej_en      (sw_ej_en),
    .ej_bus     (sw_ej_bus),
    .ej_slot    (sw_ej_slot),
    .rmv_ld_en  (sw_ld_en),
    .rmv_ld_bus (sw_ld_bus)
  );

  hp_mask_bank #(
    .NUM_BUS (NUM_BUS),
    .BUS_W   (BUS_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .plug_en    (plug_ok),
    .plug_bus   (plug_bus),
    .plug_slot  (plug_slot),
    .unp_en     (unp_ok),
    .unp_bus    (unplug_bus),
    .unp_slot   (unplug_slot),
    .rdclr_en   (rdclr_en),
    .rdclr_bus  (sel_idx),
    .ej_en      (ej_en),
    .ej_bus     (ej_bus),
    .ej_slot    (ej_slot),
    .rmv_ld_en  (sw_ld_en),
    .rmv_ld_bus (sw_ld_bus),
    .rmv_ld_val (~nohp_arr[sw_ld_bus]),
    .ins_q      (ins_q),
    .rem_q      (rem_q),
    .rmv_q      (rmv_q)
  );

  // Output strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= plug_ok | unp_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ejv_q <= 1'b0;
    else        ejv_q <= ej_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ejb_q <= '0;
      ejs_q <= '0;
    end else if (ej_en) begin
      ejb_q <= ej_bus;
      ejs_q <= ej_slot;
    end
  end

  assign event_pulse = ev_q;
  assign eject_valid = ejv_q;
  assign eject_bus   = ejb_q;
  assign eject_slot  = ejs_q;

endmodule

// File: rtl/hp_status_bank_chk.sv
module hp_status_bank_chk #(
  parameter int NUM_BUS = 8,
  parameter int BUS_W   = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        legacy_mode,
  input logic [4:0]                  reg_addr,
  input logic                        reg_rd,
  input logic                        reg_wr,
  input logic [31:0]                 reg_rdata,
  input logic                        plug_ok,
  input logic                        unp_ok,
  input logic [BUS_W-1:0]            plug_bus,
  input logic                        event_pulse,
  input logic [31:0]                 sel_q,
  input logic [NUM_BUS-1:0][31:0]    ins_q
);

  assert_event_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_ok || unp_ok) |=> event_pulse);

  assert_event_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> $past(plug_ok || unp_ok));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'h00 && !legacy_mode && !reg_wr && sel_q < NUM_BUS &&
     !(plug_ok && plug_bus == sel_q[BUS_W-1:0]))
    |=> ins_q[sel_q[BUS_W-1:0]] == 32'h0);

  assert_legacy_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h10 && legacy_mode) |=> sel_q == 32'h0);

  assert_feature_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'h08) |-> reg_rdata == 32'h0);

  assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 32'h0);

  assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_q >= NUM_BUS) |-> reg_rdata == 32'h0);

endmodule

bind hp_status_bank hp_status_bank_chk #(
  .NUM_BUS (NUM_BUS),
  .BUS_W   (BUS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .legacy_mode (legacy_mode),
  .reg_addr    (reg_addr),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_rdata   (reg_rdata),
  .plug_ok     (plug_ok),
  .unp_ok      (unp_ok),
  .plug_bus    (plug_bus),
  .event_pulse (event_pulse),
  .sel_q       (sel_q),
  .ins_q       (ins_q)
);

// File: tb/sim_hp_status_bank.sv
`timescale 1ns/1ps
module sim_hp_status_bank;

  localparam int NB = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           legacy_mode;
  logic [NB*32-1:0] nohp_mask;
  logic [4:0]     reg_addr;
  logic           reg_rd, reg_wr;
  logic [31:0]    reg_wdata, reg_rdata;
  logic           plug_valid, unplug_valid;
  logic [2:0]     plug_bus, unplug_bus;
  logic [4:0]     plug_slot, unplug_slot;
  logic           sweep_req, sweep_busy, event_pulse, eject_valid;
  logic [2:0]     eject_bus;
  logic [4:0]     eject_slot;

  int checks = 0;
  int errors = 0;

  logic [31:0] ins_m [NB];
  logic [31:0] rem_m [NB];
  logic [31:0] rmv_m [NB];
  logic [31:0] nohp_m [NB];
  logic [31:0] sel_m;

  always #5 clk = ~clk;

  always_comb begin
    for (int b = 0; b < NB; b++) nohp_mask[b*32 +: 32] = nohp_m[b];
  end

  hp_status_bank #(.NUM_BUS(NB)) u0 (
    .clk, .rst_n, .legacy_mode, .nohp_mask, .reg_addr, .reg_rd, .reg_wr,
    .reg_wdata, .reg_rdata, .plug_valid, .plug_bus, .plug_slot,
    .unplug_valid, .unplug_bus, .unplug_slot, .sweep_req, .sweep_busy,
    .event_pulse, .eject_valid, .eject_bus, .eject_slot
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int low_bit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 32;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    if (sel_m >= NB) return 32'h0;
    case (a)
      5'h00:   return ins_m[sel_m[2:0]];
      5'h04:   return rem_m[sel_m[2:0]];
      5'h0C:   return rmv_m[sel_m[2:0]];
      5'h10:   return sel_m;
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle_inputs();
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    plug_valid = 1'b0; unplug_valid = 1'b0; sweep_req = 1'b0;
    plug_bus = '0; plug_slot = '0; unplug_bus = '0; unplug_slot = '0;
  endtask

  task automatic do_event(input int bus, input int slot, input bit is_unplug);
    @(negedge clk);
    if (is_unplug) begin
      unplug_valid = 1'b1; unplug_bus = bus[2:0]; unplug_slot = slot[4:0];
    end else begin
      plug_valid = 1'b1; plug_bus = bus[2:0]; plug_slot = slot[4:0];
    end
    @(posedge clk); #1;
    idle_inputs();
    chk("R2 event_pulse", 32'(event_pulse), 32'h1);
    if (is_unplug) rem_m[bus[2:0]][slot[4:0]] = 1'b1;
    else           ins_m[bus[2:0]][slot[4:0]] = 1'b1;
  endtask

  task automatic do_rd(input logic [4:0] a, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 chk(tag, reg_rdata, exp_rd(a));
    @(posedge clk); #1;
    idle_inputs();
    if (a == 5'h00 && sel_m < NB && !legacy_mode) ins_m[sel_m[2:0]] = 32'h0;
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    bit ej_exp;
    int slot;
    logic [2:0] eb;
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    slot = low_bit(d);
    eb = sel_m[2:0];
    ej_exp = (a == 5'h08) && (sel_m < NB) && (d != 0) && !sweep_busy;
    @(posedge clk); #1;
    idle_inputs();
    chk({tag, " eject_valid"}, 32'(eject_valid), 32'(ej_exp));
    if (ej_exp) begin
      chk({tag, " eject_bus"}, 32'(eject_bus), 32'(eb));
      chk({tag, " eject_slot"}, 32'(eject_slot), slot);
      ins_m[eb][slot[4:0]] = 1'b0;
      rem_m[eb][slot[4:0]] = 1'b0;
    end
    if (a == 5'h10) sel_m = legacy_mode ? 32'h0 : d;
  endtask

  task automatic sel_bus(input logic [31:0] v);
    do_wr(5'h10, v, "R5 select");
  endtask

  // Watchdog
  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_b [256];
    int exp_s [256];
    int n_exp, n_seen;
    void'($urandom(32'd20240611));
    idle_inputs();
    legacy_mode = 1'b0;
    for (int b = 0; b < NB; b++) begin
      ins_m[b] = '0; rem_m[b] = '0; rmv_m[b] = '1; nohp_m[b] = '0;
    end
    sel_m = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 event_pulse", 32'(event_pulse), 32'h0);
    chk("R1 eject_valid", 32'(eject_valid), 32'h0);
    chk("R1 sweep_busy", 32'(sweep_busy), 32'h0);
    do_rd(5'h10, "R1 select");
    for (int b = 0; b < NB; b++) begin
      sel_bus(32'(b));
      do_rd(5'h00, "R1 insert");
      do_rd(5'h04, "R1 remove");
      do_rd(5'h0C, "R1 removable");
    end

    // R2/R3/R5: directed event and read behaviour on bus 2
    do_event(2, 5, 1'b0);
    do_event(2, 5, 1'b1);
    do_event(2, 9, 1'b1);
    sel_bus(32'd2);
    do_rd(5'h00, "R3 insert first read");
    do_rd(5'h00, "R3 insert after clear");
    do_rd(5'h04, "R5 remove read");
    do_rd(5'h04, "R5 remove reread");

    // R3: plug and clearing read in the same cycle
    do_event(2, 4, 1'b0);
    @(negedge clk);
    reg_addr = 5'h00; reg_rd = 1'b1;
    plug_valid = 1'b1; plug_bus = 3'd2; plug_slot = 5'd7;
    #1 chk("R3 read during plug", reg_rdata, 32'h0000_0010);
    @(posedge clk); #1;
    idle_inputs();
    ins_m[2] = 32'h0000_0080;
    do_rd(5'h00, "R3 plug kept over clear");

    // R8: eject lowest bit
    do_event(2, 5, 1'b0);
    do_wr(5'h08, 32'h0000_0220, "R8 eject");
    do_rd(5'h04, "R8 remove after eject");
    do_rd(5'h00, "R8 insert after eject");
    do_wr(5'h08, 32'h0, "R8 zero eject");
    do_rd(5'h04, "R8 remove after zero eject");

    // R6: feature register and undecoded offsets
    do_rd(5'h08, "R6 feature read");
    do_rd(5'h02, "R6 unaligned read");
    do_rd(5'h14, "R6 past window read");
    do_wr(5'h12, 32'h3, "R6 unaligned write");
    do_wr(5'h0A, 32'h200, "R6 unaligned eject");
    do_rd(5'h04, "R6 remove unchanged");
    @(negedge clk);
    #1 chk("R6 idle rdata", reg_rdata, 32'h0);

    // R7: out-of-range select
    do_event(3, 1, 1'b1);
    sel_bus(32'd9);
    do_rd(5'h10, "R7 select read");
    do_rd(5'h04, "R7 remove read");
    do_rd(5'h0C, "R7 removable read");
    do_wr(5'h08, 32'hFFFF_FFFF, "R7 eject ignored");
    sel_bus(32'd3);
    do_rd(5'h04, "R7 remove intact");

    // R4: legacy mode
    legacy_mode = 1'b1;
    do_event(0, 3, 1'b0);
    sel_bus(32'd5);
    do_rd(5'h10, "R4 select pinned");
    do_rd(5'h00, "R4 legacy read");
    do_rd(5'h00, "R4 legacy reread");
    legacy_mode = 1'b0;
    do_rd(5'h00, "R3 clear after legacy");

    // R2/R3/R5/R8: random traffic
    for (int it = 0; it < 500; it++) begin
      int op, bus, slot;
      op = int'($urandom % 6);
      bus = int'($urandom % NB);
      slot = int'($urandom % 32);
      case (op)
        0: do_event(bus, slot, 1'b0);
        1: do_event(bus, slot, 1'b1);
        2: sel_bus(($urandom % 8 == 0) ? 32'(NB + ($urandom % 4)) : 32'(bus));
        3: begin
          logic [4:0] a;
          a = 5'(4 * ($urandom % 5));
          do_rd(a, "R5 random read");
        end
        4: do_wr(5'h08, ($urandom % 2) ? (32'h1 << slot) | (32'h1 << ($urandom % 32))
                                        : rem_m[bus[2:0]], "R8 random eject");
        default: do_rd(5'h00, "R3 random insert read");
      endcase
    end

    // R9/R10: sweep
    for (int b = 0; b < NB; b++) nohp_m[b] = $urandom;
    do_event(1, 0, 1'b1);
    do_event(1, 31, 1'b1);
    do_event(4, 12, 1'b1);
    do_event(6, 2, 1'b1);
    do_event(6, 3, 1'b0);
    sel_bus(32'd6);
    n_exp = 0;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 32; s++)
        if (rem_m[b][s]) begin exp_b[n_exp] = b; exp_s[n_exp] = s; n_exp++; end
    @(negedge clk);
    sweep_req = 1'b1;
    @(posedge clk); #1;
    idle_inputs();
    @(negedge clk);
    chk("R9 busy raised", 32'(sweep_busy), 32'h1);
    n_seen = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (eject_valid) begin
        if (n_seen < n_exp) begin
          chk("R9 sweep eject bus", 32'(eject_bus), 32'(exp_b[n_seen]));
          chk("R9 sweep eject slot", 32'(eject_slot), 32'(exp_s[n_seen]));
        end
        n_seen++;
      end
      if (!sweep_busy) break;
      reg_wr = (cyc == 1); reg_addr = 5'h08; reg_wdata = 32'h0000_0004;
      @(negedge clk);
    end
    idle_inputs();
    chk("R10 eject count during sweep", 32'(n_seen), 32'(n_exp));
    for (int b = 0; b < NB; b++) begin
      ins_m[b] = ins_m[b] & ~rem_m[b];
      rem_m[b] = '0;
      rmv_m[b] = ~nohp_m[b];
    end
    for (int b = 0; b < NB; b++) begin
      sel_bus(32'(b));
      do_rd(5'h04, "R9 remove empty");
      do_rd(5'h0C, "R9 removable loaded");
      do_rd(5'h00, "R10 insert after sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule